// File: doc/BRIEF.md
# Fractional Amplitude Split and Phase Predistortion Datapath

This block takes one 15-bit amplitude sample per cycle and divides it into an integer part and a fractional part. The integer part goes out unchanged, for a bank of equally weighted switches. The fractional part indexes a small table that returns a pulsewidth, counted in unit delays, for one extra switch driven by a pulse. The table spaces the pulsewidth codes unevenly, so the amplitude at the carrier rises in even steps as the fractional code rises.

The pulse is aligned to an edge of the carrier, so it shifts the carrier phase. The shift grows with the pulsewidth and falls as the integer amplitude grows. The block corrects for this with a signed phase word. That word is the product of a fraction-indexed phase table and a reciprocal table indexed by the integer part. It is rounded and leaves in the same cycle as the pulsewidth it corrects. Two small tables and one 1024-entry table therefore take the place of one joint table over all 15 input bits. The approximation is good for integer codes above roughly 100 and poor below about 6.

The tables are filled through a plain write port. A bypass input forces the identity mapping for the pulsewidth and zero phase correction.

Top module: `pwm_amp_predist`

## Requirements
- R1: While reset is asserted, and in the cycles that follow release until the first sample has passed through, `int_out`, `pw_code` and `phase_corr` are zero.
- R2: `int_out` equals bits [14:5] of `amp_in` sampled two clock edges earlier.
- R3: With bypass low, `pw_code` equals the amplitude table entry addressed by `amp_in[4:0]`. It appears in the same cycle as that sample's `int_out`.
- R4: With bypass low, `phase_corr` equals floor((P*Q + 32768) / 65536), where P is the signed phase table entry at `amp_in[4:0]` and Q is the unsigned reciprocal for `amp_in[14:5]`. The value is signed 16-bit and is rounded to nearest, with ties toward positive. It appears in the same cycle as that sample's `pw_code`.
- R5: When `amp_in[14:5]` is zero, Q is 65535, whatever is stored at reciprocal address 0.
- R6: With bypass high for a sample, that sample's `pw_code` is `amp_in[4:0]` zero-extended, and its `phase_corr` is 0. Its `int_out` still follows R2.
- R7: A write takes place on a clock edge where `tbl_we` is high. `tbl_sel` encodes the target: 0 is the amplitude table (data bits [5:0], address bits [4:0]), 1 is the phase table (data bits [15:0], address bits [4:0]), and 2 is the reciprocal table (data bits [15:0], address bits [9:0]).
- R8: A write with `tbl_sel` = 3 changes no table.
- R9: A new sample is accepted on every edge. Samples on consecutive edges come out on consecutive cycles, with no interaction between them. A table write affects samples taken on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_in | input | 15 | Amplitude sample: integer in [14:5], fraction in [4:0] |
| bypass | input | 1 | Identity pulsewidth and zero phase correction for this sample |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select: 0 amplitude, 1 phase, 2 reciprocal, 3 none |
| tbl_addr | input | 10 | Table write address |
| tbl_wdata | input | 16 | Table write data |
| int_out | output | 10 | Integer amplitude for the switch bank |
| pw_code | output | 6 | Pulsewidth in unit delays for the extra switch |
| phase_corr | output | 16 | Signed phase correction word |

## Verification
On every cycle, the assertions check the behaviours that depend only on inputs two cycles back: the latency and alignment of the integer word, the identity pulsewidth and zero phase under bypass, the saturated reciprocal for a zero integer, and the reset values. The bench's scenarios are needed for the table contents: the uneven pulsewidth mapping, the rounding of signed products at the extremes of the reciprocal range, the ignored table select, and a rewrite taking effect for the next sample.

// File: rtl/pwm_amp_predist.sv
module pwm_amp_predist #(
  parameter int INT_W = 10,
  parameter int FRAC_W = 5,
  parameter int PW_W = 6,
  parameter int PH_W = 16,
  parameter int RC_W = 16,
  parameter int WD_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [INT_W+FRAC_W-1:0] amp_in,
  input  logic                   bypass,
  input  logic                   tbl_we,
  input  logic [1:0]             tbl_sel,
  input  logic [INT_W-1:0]       tbl_addr,
  input  logic [WD_W-1:0]        tbl_wdata,
  output logic [INT_W-1:0]       int_out,
  output logic [PW_W-1:0]        pw_code,
  output logic signed [PH_W-1:0] phase_corr
);
  localparam int FRAC_N = 1 << FRAC_W;
  localparam int INT_N  = 1 << INT_W;
  localparam int PROD_W = PH_W + RC_W + 1;

  logic [PW_W-1:0]        amp_tbl [FRAC_N];
  logic signed [PH_W-1:0] ph_tbl  [FRAC_N];
  logic [RC_W-1:0]        rc_tbl  [INT_N];

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      case (tbl_sel)
        2'd0: amp_tbl[tbl_addr[FRAC_W-1:0]] <= tbl_wdata[PW_W-1:0];
        2'd1: ph_tbl[tbl_addr[FRAC_W-1:0]]  <= tbl_wdata[PH_W-1:0];
        2'd2: rc_tbl[tbl_addr]              <= tbl_wdata[RC_W-1:0];
        default: ;
      endcase
    end
  end

  wire [INT_W-1:0]  int_in  = amp_in[INT_W+FRAC_W-1:FRAC_W];
  wire [FRAC_W-1:0] frac_in = amp_in[FRAC_W-1:0];

  logic [INT_W-1:0]       s1_int;
  logic [FRAC_W-1:0]      s1_frac;
  logic                   s1_byp;
  logic [PW_W-1:0]        s1_pw;
  logic signed [PH_W-1:0] s1_ph;
  logic [RC_W-1:0]        s1_rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_int  <= '0;
      s1_frac <= '0;
      s1_byp  <= 1'b0;
      s1_pw   <= '0;
      s1_ph   <= '0;
      s1_rc   <= '0;
    end else begin
      s1_int  <= int_in;
      s1_frac <= frac_in;
      s1_byp  <= bypass;
      s1_pw   <= amp_tbl[frac_in];
      s1_ph   <= ph_tbl[frac_in];
      s1_rc   <= (int_in == '0) ? '1 : rc_tbl[int_in];
    end
  end

  logic signed [PROD_W-1:0] prod, rnd;
  assign prod = s1_ph * $signed({1'b0, s1_rc});
  assign rnd  = prod + (PROD_W'(1) <<< (RC_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_out    <= '0;
      pw_code    <= '0;
      phase_corr <= '0;
    end else begin
      int_out    <= s1_int;
      pw_code    <= s1_byp ? {{(PW_W-FRAC_W){1'b0}}, s1_frac} : s1_pw;
      phase_corr <= s1_byp ? '0 : rnd[RC_W +: PH_W];
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (int_out == '0 && pw_code == '0 && phase_corr == '0));

  p_int_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    warm == 2'd2 |-> int_out == $past(int_in, 2));

  p_zero_int_recip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_in == '0 |=> s1_rc == '1);

  p_bypass_pw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && $past(bypass, 2)) |-> pw_code == PW_W'($past(frac_in, 2)));

  p_bypass_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && $past(bypass, 2)) |-> phase_corr == '0);
endmodule

// File: tb/test_pwm_amp_predist.sv
module test_pwm_amp_predist;
  logic clk = 0, rst_n = 0, bypass = 0, tbl_we = 0;
  logic [14:0] amp_in = '0;
  logic [1:0] tbl_sel = '0;
  logic [9:0] tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;
  logic [9:0] int_out;
  logic [5:0] pw_code;
  logic signed [15:0] phase_corr;

  always #10 clk = ~clk;

  pwm_amp_predist i_pwm_amp_predist (
    .clk(clk), .rst_n(rst_n), .amp_in(amp_in), .bypass(bypass),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .int_out(int_out), .pw_code(pw_code), .phase_corr(phase_corr));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [5:0]         amp_m [32];
  logic signed [15:0] ph_m  [32];
  logic [15:0]        rc_m  [1024];

  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'h001F, 16'h0020, 16'h003F, 16'h7FFF, 16'h7FE0,
    16'h0C8A, 16'h0C9A, 16'h00C3, 16'h8C8A, 16'hFFFF, 16'h2A55};

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_ph(logic [15:0] v);
    longint p, q;
    if (v[15]) return 0;
    q = (v[14:5] == 0) ? 65535 : longint'(rc_m[v[14:5]]);
    p = longint'(ph_m[v[4:0]]) * q;
    return (p + 32768) >>> 16;
  endfunction

  function automatic longint exp_pw(logic [15:0] v);
    return v[15] ? longint'(v[4:0]) : longint'(amp_m[v[4:0]]);
  endfunction

  task automatic wr(logic [1:0] s, int a, logic [15:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_sel = s; tbl_addr = 10'(a); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic check_out(logic [15:0] v);
    check("R2 int_out", int_out, v[14:5]);
    check(v[15] ? "R6 pw_code" : "R3 pw_code", pw_code, exp_pw(v));
    check(v[15] ? "R6 phase_corr" : (v[14:5] == 0 ? "R5 phase_corr" : "R4 phase_corr"),
          phase_corr, exp_ph(v));
  endtask

  task automatic single(logic [15:0] v);
    @(negedge clk);
    amp_in = v[14:0]; bypass = v[15];
    @(negedge clk);
    @(negedge clk);
    check_out(v);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      amp_m[i] = 6'((i * i * 63 + 480) / 961);
      ph_m[i]  = 16'(i * 1900 - 30000);
    end
    rc_m[0] = 16'h1234;
    for (int i = 1; i < 1024; i++) begin
      int r = (65536 + i / 2) / i;
      rc_m[i] = (r > 65535) ? 16'hFFFF : 16'(r);
    end

    repeat (3) @(negedge clk);
    check("R1 int_out reset", int_out, 0);
    check("R1 pw_code reset", pw_code, 0);
    check("R1 phase_corr reset", phase_corr, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 phase_corr after release", phase_corr, 0);

    // R7: load all three tables
    for (int i = 0; i < 32; i++) wr(2'd0, i, {10'd0, amp_m[i]});
    for (int i = 0; i < 32; i++) wr(2'd1, i, ph_m[i]);
    for (int i = 0; i < 1024; i++) wr(2'd2, i, rc_m[i]);

    // R9: back-to-back vector stream, output of vector k checked two cycles later
    for (int k = 0; k < NV + 2; k++) begin
      @(negedge clk);
      if (k >= 2) check_out(VEC[k-2]);
      if (k < NV) begin amp_in = VEC[k][14:0]; bypass = VEC[k][15]; end
    end

    // R8: select 3 writes nothing
    wr(2'd3, 10, 16'h0000);
    wr(2'd3, 100, 16'h0001);
    single(16'h0C8A);

    // R9: rewrite then later sample sees new contents
    amp_m[10] = 6'd5; ph_m[10] = -16'sd7; rc_m[100] = 16'd1;
    wr(2'd0, 10, 16'd5);
    wr(2'd1, 10, 16'hFFF9);
    wr(2'd2, 100, 16'd1);
    single(16'h0C8A);

    // R4: rounding ties, large magnitude
    ph_m[3] = 16'sh7FFF; rc_m[1] = 16'hFFFF;
    wr(2'd1, 3, 16'h7FFF);
    wr(2'd2, 1, 16'hFFFF);
    single(16'h0023);
    ph_m[3] = -16'sd32768;
    wr(2'd1, 3, 16'h8000);
    single(16'h0023);
    single(16'h0003);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule